// File: doc/BRIEF.md
# Reserved Instruction Detection Decoder

This block decides whether a 32-bit instruction word may legally execute. It takes the word, the current privilege mode and the 64-bit addressing enable bit, and raises a reserved-instruction flag when the encoding is undefined. The flag is also raised when the instruction is a doubleword operation that the current mode does not allow. A second flag shows that the cause was the mode rule rather than the encoding.

The decoder looks at three fields. The primary opcode sits in bits 31 to 26. The function field sits in bits 5 to 0 and matters when the primary opcode is 6'b000000, the register-function class. The sub-opcode sits in bits 20 to 16 and matters when the primary opcode is 6'b000001, the register-immediate class. Each field is looked up in a parameter bit-vector of defined encodings, indexed by the field value. Beside each table is a matching mask that marks which encodings are doubleword operations.

The decision is purely combinational. A parameter can add one register stage on the two outputs. The block has no enable or mask input, so the flag can never be suppressed.

Top module: `ridec_top`

## Requirements
- R1: When bit `instr[31:26]` of the primary defined-encoding vector is 0, `ri_flag` is 1, whatever the mode and the 64-bit enable.
- R2: When the primary opcode is 6'b000000, `ri_flag` is 1 if bit `instr[5:0]` of the function defined-encoding vector is 0. This holds in every mode, kernel included.
- R3: When the primary opcode is 6'b000001, `ri_flag` is 1 if bit `instr[20:16]` of the register-immediate defined-encoding vector is 0.
- R4: A defined doubleword instruction raises both `ri_flag` and `ri_mode_flag` when `ext64` is 0 and the mode is not kernel. An instruction is doubleword when its bit is set in the primary, function or register-immediate doubleword mask, the last two applying only within their class. The `mode` encoding is 2'b00 kernel, 2'b01 supervisor and 2'b10 user; 2'b11 is treated as user.
- R5: In kernel mode a defined doubleword instruction gives `ri_flag` = 0 for either value of `ext64`.
- R6: With `ext64` = 1, a defined doubleword instruction is accepted (`ri_flag` = 0) in supervisor and user mode.
- R7: A defined instruction that is not doubleword gives `ri_flag` = 0 in every mode. `ri_mode_flag` is never 1 while `ri_flag` is 0.
- R8: With `REG_OUT` = 1, both outputs show the decision for the inputs present at the previous rising clock edge. A synchronous active-low reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| instr | input | 32 | Instruction word to classify |
| mode | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 10 user, 11 as user |
| ext64 | input | 1 | 64-bit addressing enable for supervisor and user mode |
| ri_flag | output | 1 | Reserved-instruction exception request |
| ri_mode_flag | output | 1 | Request caused by the doubleword mode rule |

## Verification
Four properties are checked on every cycle:
- an undefined primary opcode always reaches the combinational flag;
- kernel mode and a set 64-bit enable never produce a mode fault;
- a mode fault always comes with the flag;
- the registered outputs follow the combinational decision one cycle later.

Only the bench scenarios can show the following:
- undefined function and register-immediate sub-opcodes within their classes;
- doubleword masks applied to the correct class;
- defined non-doubleword words accepted in mode 2'b11;
- the cleared outputs during reset.

// File: rtl/ridec_pkg.sv
// Package: shared field widths and the privilege mode encoding.
// Assumes the 32-bit word layout with the primary opcode in the top six bits.
package ridec_pkg;
    localparam int OPC_W = 6;
    localparam int FUN_W = 6;
    localparam int RIM_W = 5;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_SUPER  = 2'b01,
        MODE_USER   = 2'b10,
        MODE_USERX  = 2'b11
    } priv_mode_t;

    localparam logic [OPC_W-1:0] OPC_REGFN  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_REGIMM = 6'b000001;
endpackage

// File: rtl/ridec_table_lookup.sv
// Module: indexes a defined-encoding vector and a doubleword mask with one field.
// Assumes both vectors have 2**W entries, bit i belonging to field value i.
module ridec_table_lookup #(
    parameter int W = 6,
    parameter logic [(1<<W)-1:0] DEF = '1,
    parameter logic [(1<<W)-1:0] DW  = '0
) (
    input  logic [W-1:0] idx,
    output logic         defined,
    output logic         dword
);
    localparam int N = 1 << W;
    localparam logic [N-1:0] DEF_V = DEF;
    localparam logic [N-1:0] DW_V  = DW;

    // Select the two table bits belonging to the field value.
    always_comb begin
        defined = DEF_V[idx];
        dword   = DW_V[idx];
    end
endmodule

// File: rtl/ridec_mode_gate.sv
// Module: decides whether a doubleword operation is allowed in the current mode.
// Assumes the mode encoding from ridec_pkg; any non-kernel value is unprivileged.
module ridec_mode_gate
    import ridec_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       ext64,
    input  logic       is_dword,
    input  logic       enc_ok,
    output logic       mode_fault
);
    logic allow64;

    // Kernel always allows doubleword work; otherwise the enable bit decides.
    always_comb begin
        allow64    = (mode == MODE_KERNEL) || ext64;
        mode_fault = enc_ok && is_dword && !allow64;
    end
endmodule

// File: rtl/ridec_out_stage.sv
// Module: optional output register, chosen by REG at elaboration.
// Assumes a synchronous active-low reset that clears both flags.
module ridec_out_stage #(
    parameter bit REG = 1'b0,
    parameter int W   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG) begin : g_reg
            logic [W-1:0] q_r;
            // Capture the decision on each rising edge, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/ridec_top.sv
// Module: reserved-instruction detection for one 32-bit word.
// Assumes the class opcodes from ridec_pkg. Sub-field tables only count inside
// their class, and a word whose primary opcode is undefined is never mode-faulted.
module ridec_top
    import ridec_pkg::*;
#(
    parameter logic [63:0] OPC_DEF = 64'h0FFF_FFFF_FFFF_FFFF,
    parameter logic [63:0] FUN_DEF = 64'hFFFF_FFFF_FFFF_FFFF,
    parameter logic [31:0] RIM_DEF = 32'h000F_FFFF,
    parameter logic [63:0] OPC_DW  = 64'h0F00_0000_0000_0000,
    parameter logic [63:0] FUN_DW  = 64'hFF00_0000_0000_0000,
    parameter logic [31:0] RIM_DW  = 32'h0000_0000,
    parameter bit          REG_OUT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr,
    input  logic [1:0]  mode,
    input  logic        ext64,
    output logic        ri_flag,
    output logic        ri_mode_flag
);
    logic [OPC_W-1:0] opc;
    logic [FUN_W-1:0] fun;
    logic [RIM_W-1:0] rim;
    logic opc_def, opc_dw, fun_def, fun_dw, rim_def, rim_dw;
    logic is_regfn, is_regimm, enc_ok, is_dword;
    logic core_ri, core_mode;

    // Split the word into the three fields.
    always_comb begin
        opc = instr[31:26];
        fun = instr[5:0];
        rim = instr[20:16];
    end

    ridec_table_lookup #(.W(OPC_W), .DEF(OPC_DEF), .DW(OPC_DW)) u_opc (
        .idx(opc), .defined(opc_def), .dword(opc_dw));
    ridec_table_lookup #(.W(FUN_W), .DEF(FUN_DEF), .DW(FUN_DW)) u_fun (
        .idx(fun), .defined(fun_def), .dword(fun_dw));
    ridec_table_lookup #(.W(RIM_W), .DEF(RIM_DEF), .DW(RIM_DW)) u_rim (
        .idx(rim), .defined(rim_def), .dword(rim_dw));

    // Combine the class-qualified lookups into legality and doubleword status.
    always_comb begin
        is_regfn  = (opc == OPC_REGFN);
        is_regimm = (opc == OPC_REGIMM);
        enc_ok    = opc_def && (!is_regfn || fun_def) && (!is_regimm || rim_def);
        is_dword  = opc_dw || (is_regfn && fun_dw) || (is_regimm && rim_dw);
    end

    ridec_mode_gate u_gate (
        .mode(mode), .ext64(ext64), .is_dword(is_dword),
        .enc_ok(enc_ok), .mode_fault(core_mode));

    // Any undefined encoding or a mode fault requests the exception.
    always_comb core_ri = !enc_ok || core_mode;

    ridec_out_stage #(.REG(REG_OUT), .W(2)) u_out (
        .clk(clk), .rst_n(rst_n),
        .d({core_ri, core_mode}),
        .q({ri_flag, ri_mode_flag}));
endmodule

// File: rtl/ridec_checker.sv
// Module: per-cycle properties of the decoder, bound into ridec_top.
// Assumes it observes the combinational decision ahead of the output stage.
module ridec_checker #(
    parameter logic [63:0] OPC_DEF = '1,
    parameter bit          REG_OUT = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr,
    input logic [1:0]  mode,
    input logic        ext64,
    input logic        core_ri,
    input logic        core_mode,
    input logic        ri_flag
);
    assert_primary_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !OPC_DEF[instr[31:26]] |-> core_ri);
    assert_kernel_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !core_mode);
    assert_ext64_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext64 |-> !core_mode);
    assert_mode_implies_ri_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_mode |-> core_ri);

    generate
        if (REG_OUT) begin : g_stage
            assert_stage_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (ri_flag == $past(core_ri)));
        end
    endgenerate
endmodule

bind ridec_top ridec_checker #(.OPC_DEF(OPC_DEF), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr(instr), .mode(mode), .ext64(ext64),
    .core_ri(core_ri), .core_mode(core_mode), .ri_flag(ri_flag));

// File: tb/ridec_top_test.sv
// Bench: a scoreboard for the registered decoder. The driver pushes expected
// flags at each falling edge, and the monitor pops and compares them after
// the next rising edge.
module ridec_top_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] T_OPC_DEF = 64'hDEAD_BEEF_F0F0_0F03;
    localparam logic [63:0] T_FUN_DEF = 64'hFFFF_0000_FFFF_00FF;
    localparam logic [31:0] T_RIM_DEF = 32'h0F0F_00FF;
    localparam logic [63:0] T_OPC_DW  = 64'h0000_0003_0000_0000;
    localparam logic [63:0] T_FUN_DW  = 64'h0000_0000_0000_00F0;
    localparam logic [31:0] T_RIM_DW  = 32'h0000_0003;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0] mode = 2'b00;
    logic ext64 = 1'b0;
    logic ri_flag, ri_mode_flag;

    int checks = 0;
    int fails = 0;
    logic [1:0] exp_q[$];
    string tag_q[$];

    ridec_top #(
        .OPC_DEF(T_OPC_DEF), .FUN_DEF(T_FUN_DEF), .RIM_DEF(T_RIM_DEF),
        .OPC_DW(T_OPC_DW), .FUN_DW(T_FUN_DW), .RIM_DW(T_RIM_DW), .REG_OUT(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .mode(mode), .ext64(ext64),
        .ri_flag(ri_flag), .ri_mode_flag(ri_mode_flag));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference decision written from the requirements: returns {ri, mode}.
    function automatic logic [1:0] model(input logic [31:0] w, input logic [1:0] m,
                                         input logic e);
        logic [5:0] o;
        logic legal, dw, flt;
        o = w[31:26];
        legal = T_OPC_DEF[o];
        dw = T_OPC_DW[o];
        if (o == 6'd0) begin
            legal = legal && T_FUN_DEF[w[5:0]];
            dw = dw || T_FUN_DW[w[5:0]];
        end
        if (o == 6'd1) begin
            legal = legal && T_RIM_DEF[w[20:16]];
            dw = dw || T_RIM_DW[w[20:16]];
        end
        flt = legal && dw && (m != 2'b00) && !e;
        return {!legal || flt, flt};
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] o, input logic [4:0] rt,
                                       input logic [5:0] f);
        return {o, 5'd3, rt, 5'd7, 5'd0, f};
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ri/mode actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [31:0] w, input logic [1:0] m,
                         input logic e);
        @(negedge clk);
        instr = w;
        mode = m;
        ext64 = e;
        exp_q.push_back(model(w, m, e));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the registered result a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) check(tag_q.pop_front(), {ri_flag, ri_mode_flag}, exp_q.pop_front());
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        instr = mk(6'd2, 5'd0, 6'd0);
        mode = 2'b10;
        repeat (3) @(negedge clk);
        check("R8 reset clears outputs", {ri_flag, ri_mode_flag}, 2'b00);
        rst_n = 1'b1;
        drive("R1 undefined primary 2", mk(6'd2, 5'd0, 6'd0), 2'b00, 1'b1);
        drive("R1 undefined primary 12 kernel", mk(6'd12, 5'd0, 6'd0), 2'b00, 1'b0);
        drive("R7 defined primary 8 user", mk(6'd8, 5'd0, 6'd0), 2'b10, 1'b0);
        drive("R2 undefined function 8", mk(6'd0, 5'd0, 6'd8), 2'b10, 1'b1);
        drive("R2 undefined function in kernel", mk(6'd0, 5'd0, 6'd12), 2'b00, 1'b1);
        drive("R7 defined function 3", mk(6'd0, 5'd0, 6'd3), 2'b10, 1'b0);
        drive("R4 dword function user", mk(6'd0, 5'd0, 6'd5), 2'b10, 1'b0);
        drive("R4 dword function supervisor", mk(6'd0, 5'd0, 6'd6), 2'b01, 1'b0);
        drive("R5 dword function kernel ext0", mk(6'd0, 5'd0, 6'd5), 2'b00, 1'b0);
        drive("R5 dword function kernel ext1", mk(6'd0, 5'd0, 6'd5), 2'b00, 1'b1);
        drive("R6 dword function user ext1", mk(6'd0, 5'd0, 6'd7), 2'b10, 1'b1);
        drive("R3 undefined regimm 8", mk(6'd1, 5'd8, 6'd0), 2'b00, 1'b0);
        drive("R4 dword regimm user", mk(6'd1, 5'd1, 6'd0), 2'b10, 1'b0);
        drive("R7 plain regimm user", mk(6'd1, 5'd2, 6'd0), 2'b10, 1'b0);
        drive("R4 dword primary 32 user", mk(6'd32, 5'd1, 6'd5), 2'b10, 1'b0);
        drive("R4 dword primary 33 mode 11", mk(6'd33, 5'd0, 6'd0), 2'b11, 1'b0);
        drive("R6 dword primary supervisor ext1", mk(6'd33, 5'd0, 6'd0), 2'b01, 1'b1);
        drive("R5 dword primary kernel", mk(6'd32, 5'd0, 6'd0), 2'b00, 1'b0);
        drive("R7 function mask ignored outside class", mk(6'd8, 5'd1, 6'd5), 2'b10, 1'b0);
        drive("R7 defined primary mode 11", mk(6'd8, 5'd0, 6'd0), 2'b11, 1'b0);
        @(negedge clk);
        @(negedge clk);
        instr = mk(6'd2, 5'd0, 6'd0);
        #1;
        check("R8 output holds before edge", {ri_flag, ri_mode_flag}, 2'b00);
        @(posedge clk);
        #(CLK_PERIOD/4 + 1);
        check("R8 output after edge", {ri_flag, ri_mode_flag}, 2'b10);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule